// File: doc/BRIEF.md
# SerDes Control Register Access Master

This block gives a client a single-word read or write to a SerDes lane's internal control registers. It cannot reach those registers directly. Every access goes through a small paged window on a synchronous memory-mapped bus, and every control access runs as a handshake with three registers inside the lane: control, address and data. The block is told which lane device to use through a 5-bit selector. It then carries out the whole sequence on its own: page selects, busy polling with a fixed back-off, loading the address and data, the start command, and, for reads, fetching the result.

The client side has a valid/ready request with a write flag, a 16-bit target address, 16-bit write data and the device selector. Completion is a one-cycle done strobe that carries read data. Only one transaction runs at a time. On the bus side, reads return data a fixed number of cycles after the read strobe. The back-off interval between busy polls and the read latency are parameters counted in clock cycles.

Top module: `serdes_cr_master`

## Requirements
- R1: After reset the block shows request-ready high and done low, and it issues no bus read or write strobe until a request is accepted.
- R2: Every window access is preceded, in the cycle just before, by a bus write to byte offset 0x800. The data of that write is ((dev & 0x1f) << 7) | ((reg >> 9) & 0x7f), where reg is the 16-bit lane register being accessed. The window access itself goes to byte offset (reg & 0x1ff) << 2.
- R3: The lane's control register is 0x80a0, its address register 0x80a1 and its data register 0x80a2. Bit 0 of a control read is the busy flag. Window offsets are therefore 0x280, 0x284 and 0x288, and the page word is (dev << 7) | 0x40.
- R4: When a control read returns busy, the next page write comes exactly RD_LAT + WAIT_CYC + 1 cycles after that read strobe. When it returns not-busy, the next strobe comes RD_LAT + 1 cycles after it. Polling repeats until not-busy.
- R5: A read polls control until not-busy, writes the target address to the address register, writes 0x0001 to control, polls until not-busy again, then reads the data register. The value read is returned on rsp_rdata.
- R6: A write polls control until not-busy, writes the target address, writes the data to the data register, then writes 0x0003 to control. It polls no further, and done is pulsed in the cycle after that last write strobe.
- R7: Request-ready falls in the cycle after a request is accepted and stays low until done. Done lasts one cycle and request-ready is high in that cycle.
- R8: Bus read data is sampled exactly RD_LAT cycles after the read strobe cycle. For a read, done is pulsed RD_LAT + 1 cycles after the data-register read strobe.
- R9: Bus write and bus read strobes are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 16 | Lane control register address to access |
| req_wdata | input | 16 | Data for a write |
| req_dev | input | 5 | Lane device selector placed in the page word |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 16 | Read result, valid with rsp_done after a read |
| bus_addr | output | 12 | Byte offset on the window bus |
| bus_we | output | 1 | Bus write strobe |
| bus_re | output | 1 | Bus read strobe |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data, valid RD_LAT cycles after bus_re |

## Verification
Transactions run against a lane model whose busy count is set by each start command. This gives patterns with no busy at all, with busy left over from a previous write (only the first poll loop can see this), and with several busy replies after a read start (only the second poll loop can see these). Together they separate the two poll loops and show whether the back-off delay is applied only on busy. Device selectors at 0 and 0x1f, and targets whose upper byte varies, show whether the page word is built from the device and the lane register rather than from the target address. Reading back locations that were just written tells whether address, data and command were loaded in the right order. The same reads also check that data is sampled at the stated latency, because the model drives valid data on the bus for only that one cycle.

// File: rtl/serdes_cr_pkg.sv
package serdes_cr_pkg;

  localparam int unsigned CR_AW = 16;

  localparam logic [CR_AW-1:0] CR_REG_CTL = 16'h80a0;
  localparam logic [CR_AW-1:0] CR_REG_ADR = 16'h80a1;
  localparam logic [CR_AW-1:0] CR_REG_DAT = 16'h80a2;

  localparam logic [CR_AW-1:0] CR_CMD_RD  = 16'h0001;
  localparam logic [CR_AW-1:0] CR_CMD_WR  = 16'h0003;

  localparam int unsigned CR_BUSY_BIT = 0;

  localparam logic [11:0] WIN_PAGE_OFF = 12'h800;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PAGE,
    PH_ACCESS,
    PH_LATENCY,
    PH_BACKOFF
  } phase_t;

  typedef enum logic [2:0] {
    SP_POLL_PRE,
    SP_LOAD_ADR,
    SP_LOAD_DAT,
    SP_KICK,
    SP_POLL_POST,
    SP_FETCH
  } step_t;

endpackage

// File: rtl/cr_window_map.sv
module cr_window_map
  import serdes_cr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEV_W  = 5
) (
  input  logic [DEV_W-1:0]  dev,
  input  logic [CR_AW-1:0]  ctl_reg,
  output logic [DATA_W-1:0] page_word,
  output logic [ADDR_W-1:0] win_off
);

  // page = device selector above the upper seven register address bits
  assign page_word = DATA_W'({dev, ctl_reg[CR_AW-1:9]});
  // window offset = low nine register bits as a word index
  assign win_off   = ADDR_W'({ctl_reg[8:0], 2'b00});

endmodule

// File: rtl/cr_down_timer.sv
module cr_down_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/cr_access_fsm.sv
module cr_access_fsm
  import serdes_cr_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned DEV_W    = 5,
  parameter int unsigned WAIT_CYC = 4,
  parameter int unsigned RD_LAT   = 1,
  parameter int unsigned CNT_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [CR_AW-1:0]  req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              tmr_zero,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              acc_page,
  output logic              acc_win,
  output logic              acc_read,
  output logic [DATA_W-1:0] acc_wdata,
  output logic [CR_AW-1:0]  cur_reg,
  output logic [DEV_W-1:0]  cur_dev,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val
);

  phase_t phase_q, phase_d;
  step_t  step_q, step_d, step_nx;
  logic   done_q, done_d;
  logic   cap_req, cap_rd;

  logic              is_wr_q;
  logic [CR_AW-1:0]  tgt_q;
  logic [DATA_W-1:0] wdat_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DEV_W-1:0]  dev_q;

  logic              step_rd;
  logic [CR_AW-1:0]  step_reg;
  logic [DATA_W-1:0] step_dat;

  // per-step decode: which lane register, direction, payload, successor
  always_comb begin
    step_rd  = 1'b0;
    step_reg = CR_REG_CTL;
    step_dat = '0;
    step_nx  = step_q;
    case (step_q)
      SP_POLL_PRE: begin
        step_rd = 1'b1;
        step_nx = SP_LOAD_ADR;
      end
      SP_LOAD_ADR: begin
        step_reg = CR_REG_ADR;
        step_dat = DATA_W'(tgt_q);
        step_nx  = is_wr_q ? SP_LOAD_DAT : SP_KICK;
      end
      SP_LOAD_DAT: begin
        step_reg = CR_REG_DAT;
        step_dat = wdat_q;
        step_nx  = SP_KICK;
      end
      SP_KICK: begin
        step_dat = DATA_W'(is_wr_q ? CR_CMD_WR : CR_CMD_RD);
        step_nx  = SP_POLL_POST;
      end
      SP_POLL_POST: begin
        step_rd = 1'b1;
        step_nx = SP_FETCH;
      end
      SP_FETCH: begin
        step_reg = CR_REG_DAT;
        step_rd  = 1'b1;
      end
      default: ;
    endcase
  end

  // next-state
  always_comb begin
    phase_d  = phase_q;
    step_d   = step_q;
    done_d   = 1'b0;
    cap_req  = 1'b0;
    cap_rd   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          cap_req = 1'b1;
          step_d  = SP_POLL_PRE;
          phase_d = PH_PAGE;
        end
      end
      PH_PAGE: begin
        phase_d = PH_ACCESS;
      end
      PH_ACCESS: begin
        if (step_rd) begin
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(RD_LAT - 1);
          phase_d  = PH_LATENCY;
        end else if ((step_q == SP_KICK) && is_wr_q) begin
          done_d  = 1'b1;
          phase_d = PH_IDLE;
        end else begin
          step_d  = step_nx;
          phase_d = PH_PAGE;
        end
      end
      PH_LATENCY: begin
        if (tmr_zero) begin
          if (step_q == SP_FETCH) begin
            cap_rd  = 1'b1;
            done_d  = 1'b1;
            phase_d = PH_IDLE;
          end else if (bus_rdata[CR_BUSY_BIT]) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(WAIT_CYC - 1);
            phase_d  = PH_BACKOFF;
          end else begin
            step_d  = step_nx;
            phase_d = PH_PAGE;
          end
        end
      end
      PH_BACKOFF: begin
        if (tmr_zero) begin
          phase_d = PH_PAGE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      step_q  <= SP_POLL_PRE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      done_q  <= done_d;
    end
  end

  // request capture, enabled on acceptance only
  always_ff @(posedge clk) begin
    if (cap_req) begin
      is_wr_q <= req_write;
      tgt_q   <= req_addr;
      wdat_q  <= req_wdata;
      dev_q   <= req_dev;
    end
  end

  // result capture, enabled on the data-register sample only
  always_ff @(posedge clk) begin
    if (cap_rd) begin
      rdata_q <= bus_rdata;
    end
  end

  assign req_ready = (phase_q == PH_IDLE);
  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;
  assign acc_page  = (phase_q == PH_PAGE);
  assign acc_win   = (phase_q == PH_ACCESS);
  assign acc_read  = step_rd;
  assign acc_wdata = step_dat;
  assign cur_reg   = step_reg;
  assign cur_dev   = dev_q;

endmodule

// File: rtl/serdes_cr_master.sv
module serdes_cr_master
  import serdes_cr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned DEV_W    = 5,
  parameter int unsigned WAIT_CYC = 250,
  parameter int unsigned RD_LAT   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CR_AW-1:0]  req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DEV_W-1:0]  req_dev,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_we,
  output logic              bus_re,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);

  localparam int unsigned SPAN  = (WAIT_CYC > RD_LAT) ? WAIT_CYC : RD_LAT;
  localparam int unsigned CNT_W = $clog2(SPAN + 1);
  localparam logic [ADDR_W-1:0] PAGE_OFF = ADDR_W'(WIN_PAGE_OFF);

  if (RD_LAT < 1) begin : g_bad_lat
    $error("RD_LAT must be at least one cycle");
  end
  if (WAIT_CYC < 1) begin : g_bad_wait
    $error("WAIT_CYC must be at least one cycle");
  end

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic              acc_page, acc_win, acc_read;
  logic [DATA_W-1:0] acc_wdata;
  logic [CR_AW-1:0]  cur_reg;
  logic [DEV_W-1:0]  cur_dev;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  logic [DATA_W-1:0] page_word;
  logic [ADDR_W-1:0] win_off;

  cr_access_fsm #(
    .DATA_W  (DATA_W),
    .DEV_W   (DEV_W),
    .WAIT_CYC(WAIT_CYC),
    .RD_LAT  (RD_LAT),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_dev  (req_dev),
    .bus_rdata(bus_rdata),
    .tmr_zero (tmr_zero),
    .req_ready(req_ready),
    .rsp_done (rsp_done),
    .rsp_rdata(rsp_rdata),
    .acc_page (acc_page),
    .acc_win  (acc_win),
    .acc_read (acc_read),
    .acc_wdata(acc_wdata),
    .cur_reg  (cur_reg),
    .cur_dev  (cur_dev),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val)
  );

  cr_down_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync),
    .load    (tmr_load),
    .load_val(tmr_val),
    .zero    (tmr_zero)
  );

  cr_window_map #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .DEV_W (DEV_W)
  ) u_map (
    .dev      (cur_dev),
    .ctl_reg  (cur_reg),
    .page_word(page_word),
    .win_off  (win_off)
  );

  always_comb begin
    bus_we    = acc_page | (acc_win & ~acc_read);
    bus_re    = acc_win & acc_read;
    bus_addr  = acc_page ? PAGE_OFF : (acc_win ? win_off : '0);
    bus_wdata = acc_page ? page_word : (acc_win ? acc_wdata : '0);
  end

endmodule

// File: rtl/serdes_cr_checker.sv
module serdes_cr_checker
  import serdes_cr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              bus_we,
  input logic              bus_re,
  input logic [ADDR_W-1:0] bus_addr
);

  localparam logic [ADDR_W-1:0] PAGE_OFF = ADDR_W'(WIN_PAGE_OFF);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(bus_we || bus_re));

  assert_page_before_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_we || bus_re) && (bus_addr != PAGE_OFF)) |-> $past(bus_we && (bus_addr == PAGE_OFF)));

  assert_window_after_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == PAGE_OFF)) |=> ((bus_we || bus_re) && (bus_addr != PAGE_OFF)));

  assert_ready_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_done_with_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

endmodule

bind serdes_cr_master serdes_cr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_done (rsp_done),
  .bus_we   (bus_we),
  .bus_re   (bus_re),
  .bus_addr (bus_addr)
);

// File: tb/serdes_cr_master_test.sv
`timescale 1ns/1ps
module serdes_cr_master_test;

  localparam int WAIT_CYC = 3;
  localparam int RD_LAT   = 2;
  localparam int LOGN     = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [4:0]  req_dev = '0;
  logic        req_ready, rsp_done, bus_we, bus_re;
  logic [15:0] rsp_rdata, bus_wdata;
  logic [15:0] bus_rdata = 16'hdead;
  logic [11:0] bus_addr;

  always #2 clk = ~clk;

  serdes_cr_master #(
    .ADDR_W(12), .DATA_W(16), .DEV_W(5), .WAIT_CYC(WAIT_CYC), .RD_LAT(RD_LAT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_dev(req_dev), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- lane model and bus monitor ----------------
  logic [15:0] m_page, m_areg, m_dreg, rd_val;
  logic [15:0] m_mem [256];
  int m_busy = 2;
  int plan_b2 = 0;
  int rd_cnt = 0;
  int log_n = 0;
  logic        log_we   [LOGN];
  logic [11:0] log_addr [LOGN];
  logic [15:0] log_data [LOGN];
  int          log_cyc  [LOGN];
  int done_cnt = 0, done_cyc = 0, dual_cnt = 0;
  logic [15:0] done_data;
  logic done_rdy;

  function automatic logic [15:0] seed_val(int i);
    return 16'(i * 257) ^ 16'h5a5a;
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) m_mem[i] = seed_val(i);
  end

  always @(negedge clk) begin : model
    logic [15:0] full;
    bus_rdata = 16'hdead;
    if (rd_cnt != 0) begin
      if (rd_cnt == 1) bus_rdata = rd_val;
      rd_cnt--;
    end
    if (bus_we && bus_re) dual_cnt++;
    if (bus_we || bus_re) begin
      if (log_n < LOGN) begin
        log_we[log_n] = bus_we; log_addr[log_n] = bus_addr;
        log_data[log_n] = bus_wdata; log_cyc[log_n] = cyc;
        log_n++;
      end
      full = {m_page[6:0], bus_addr[10:2]};
      if (bus_we) begin
        if (bus_addr == 12'h800) m_page = bus_wdata;
        else if (full == 16'h80a1) m_areg = bus_wdata;
        else if (full == 16'h80a2) m_dreg = bus_wdata;
        else if (full == 16'h80a0 && bus_wdata[0]) begin
          if (bus_wdata[1]) m_mem[m_areg[7:0]] = m_dreg;
          else m_dreg = m_mem[m_areg[7:0]];
          m_busy = plan_b2;
        end
      end else begin
        if (full == 16'h80a0) begin
          rd_val = {15'd0, m_busy != 0};
          if (m_busy != 0) m_busy--;
        end else if (full == 16'h80a2) rd_val = m_dreg;
        else if (full == 16'h80a1) rd_val = m_areg;
        else rd_val = 16'hbad0;
        rd_cnt = RD_LAT;
      end
    end
    if (rsp_done) begin
      done_cnt++; done_cyc = cyc; done_data = rsp_rdata; done_rdy = req_ready;
    end
  end

  // ---------------- expected sequence and checking ----------------
  int n_chk = 0, n_bad = 0;
  logic [15:0] e_mem [256];
  int e_resid = 2;
  int ex_n, nxt_gap;
  logic        ex_we   [256];
  logic [11:0] ex_addr [256];
  logic [15:0] ex_data [256];
  int          ex_gap  [256];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] page_of(logic [4:0] dev);
    return {4'd0, dev, 7'h40};
  endfunction

  task automatic push(input logic we, input logic [11:0] a, input logic [15:0] d);
    ex_we[ex_n] = we; ex_addr[ex_n] = a; ex_data[ex_n] = d; ex_gap[ex_n] = nxt_gap;
    ex_n++;
    nxt_gap = 1;
  endtask

  task automatic push_poll(input logic [15:0] pg, input int nb);
    for (int k = 0; k <= nb; k++) begin
      push(1'b1, 12'h800, pg);
      push(1'b0, 12'h280, 16'h0);
      nxt_gap = (k < nb) ? (RD_LAT + WAIT_CYC + 1) : (RD_LAT + 1);
    end
  endtask

  task automatic run_txn(input bit wr, input logic [15:0] a, input logic [15:0] d,
                         input logic [4:0] dev, input int b2);
    int log0, dn0, acc, guard, done_gap, got, bad_i, prev;
    bit seq_ok, gap_ok;
    logic [15:0] pg;
    string tag;
    pg = page_of(dev);
    tag = wr ? "R6" : "R5";
    ex_n = 0; nxt_gap = 1;
    push_poll(pg, e_resid);
    push(1'b1, 12'h800, pg); push(1'b1, 12'h284, a);
    if (wr) begin
      push(1'b1, 12'h800, pg); push(1'b1, 12'h288, d);
      push(1'b1, 12'h800, pg); push(1'b1, 12'h280, 16'h0003);
      done_gap = 1;
    end else begin
      push(1'b1, 12'h800, pg); push(1'b1, 12'h280, 16'h0001);
      push_poll(pg, b2);
      push(1'b1, 12'h800, pg); push(1'b0, 12'h288, 16'h0);
      done_gap = RD_LAT + 1;
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    plan_b2 = b2; log0 = log_n; dn0 = done_cnt; acc = cyc;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_dev = dev;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R7", "ready after accept", {31'd0, req_ready}, 32'd0);
    guard = 0;
    while (done_cnt == dn0 && guard < 3000) begin @(posedge clk); guard++; end
    if (done_cnt == dn0) begin
      check(1'b0, "R7", "transaction completion", 32'd0, 32'd1);
      return;
    end
    got = log_n - log0;
    check(got == ex_n, tag, "bus strobe count (R2 R3)", 32'(got), 32'(ex_n));
    seq_ok = 1'b1; gap_ok = 1'b1; bad_i = -1;
    for (int i = 0; i < ex_n && i < got; i++) begin
      if (log_we[log0+i] !== ex_we[i] || log_addr[log0+i] !== ex_addr[i] ||
          (ex_we[i] && log_data[log0+i] !== ex_data[i])) begin
        if (seq_ok) bad_i = i;
        seq_ok = 1'b0;
      end
      prev = (i == 0) ? acc : log_cyc[log0+i-1];
      if (log_cyc[log0+i] - prev != ex_gap[i]) gap_ok = 1'b0;
    end
    if (bad_i >= 0)
      check(1'b0, tag, "bus access order/value R2 R3",
            {log_addr[log0+bad_i], 4'd0, log_data[log0+bad_i]},
            {ex_addr[bad_i], 4'd0, ex_data[bad_i]});
    else
      check(1'b1, tag, "bus access order/value R2 R3", 32'd0, 32'd0);
    check(gap_ok, "R4", "strobe spacing incl. back-off", 32'd0, 32'd1);
    if (got > 0)
      check(done_cyc - log_cyc[log_n-1] == done_gap, wr ? "R6" : "R8",
            "done delay after last strobe", 32'(done_cyc - log_cyc[log_n-1]), 32'(done_gap));
    check(done_rdy, "R7", "ready during done", {31'd0, done_rdy}, 32'd1);
    if (wr) begin
      e_mem[a[7:0]] = d;
      e_resid = b2;
    end else begin
      check(done_data == e_mem[a[7:0]], "R5", "read data", 32'(done_data), 32'(e_mem[a[7:0]]));
      e_resid = 0;
    end
  endtask

  initial begin : watchdog
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    bit ok;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) e_mem[i] = seed_val(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!req_ready || rsp_done) ok = 1'b0;
    end
    check(ok && log_n == 0, "R1", "reset state", {30'd0, req_ready, rsp_done}, 32'd2);

    // directed corners
    run_txn(1'b0, 16'h0000, 16'h0000, 5'h00, 0);   // leftover busy on first poll only
    run_txn(1'b1, 16'h0012, 16'hbeef, 5'h1f, 3);   // top device, busy left for next
    run_txn(1'b0, 16'h0012, 16'h0000, 5'h1f, 2);   // both poll loops busy
    run_txn(1'b1, 16'hffff, 16'h1234, 5'h05, 0);
    run_txn(1'b0, 16'hffff, 16'h0000, 5'h05, 0);   // no busy at all
    run_txn(1'b1, 16'h0a03, 16'h0f0f, 5'h10, 1);
    run_txn(1'b1, 16'h3303, 16'h7777, 5'h02, 0);   // back-to-back writes, same slot
    run_txn(1'b0, 16'h9903, 16'h0000, 5'h0a, 4);

    // constrained random traffic
    for (int n = 0; n < 40; n++) begin
      run_txn(1'($urandom % 2), {8'($urandom), 4'h0, 4'($urandom)}, 16'($urandom),
              5'($urandom), int'($urandom % 4));
    end

    check(dual_cnt == 0, "R9", "cycles with both strobes", 32'(dual_cnt), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule